// File: doc/BRIEF.md
# AAD and Payload Lane Packer

This block sits in front of an authenticated-encryption core whose datapath is four 128-bit lanes wide. It takes a single byte-wide stream that carries a message's associated data (AAD) followed by its payload, and packs both into 512-bit words. Each byte is tagged as AAD or payload. A start pulse sets the two byte counts for the message.

The AAD is padded with zero bytes only up to the next 16-byte lane boundary, not up to a full word. The payload then continues in the next free lane of the same word. Bytes fill each word from the most significant end down. Unused bytes after the final payload byte are zero. The final word of a message carries a last flag. A completed word is held until the consumer pulses the read strobe, and the byte input is stalled for as long as a word is held.

Top module: `aad_lane_packer`

## Requirements
- R1: Within a word, byte position k (0 to 63) occupies bits [511-8k : 504-8k], so the first byte written to a word lands in [511:504].
- R2: When the AAD length is not a multiple of 16, the remaining bytes of its last 16-byte lane are zero.
- R3: The first payload byte lands at the first 16-byte lane boundary after the padded AAD, in the same word if one is free there, otherwise at byte 0 of the next word.
- R4: With an AAD count of zero, the first payload byte is byte 0 of word 0.
- R5: With a payload count of zero, the word holding the last AAD byte is the final word of the message, and its bytes after the AAD padding are zero.
- R6: Bytes after the final payload byte in the final word are zero, and `out_last` is 1 on the final word only.
- R7: A word is presented with `out_valid` only once it is full or holds the message's final byte. It stays valid and unchanged until `out_rd` is sampled high, and `in_ready` is 0 while a word is held.
- R8: Byte counts are captured on a `start` pulse while the block is idle. A `start` pulse, or a change of the count inputs, during a message has no effect on that message's output.
- R9: A byte whose tag (`in_is_aad`: 1 = AAD, 0 = payload) does not match the stream currently being collected is not accepted (`in_ready` is 0).
- R10: A message with both counts zero produces no output word.
- R11: After reset, `out_valid`, `out_last` and `in_ready` are 0 and `out_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a message and capture both counts |
| aad_len | input | 16 | AAD byte count |
| pay_len | input | 16 | Payload byte count |
| in_valid | input | 1 | Input byte is valid |
| in_is_aad | input | 1 | Tag: 1 for an AAD byte, 0 for a payload byte |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the byte in this cycle |
| out_valid | output | 1 | Packed word is held and valid |
| out_rd | input | 1 | Consumer takes the held word |
| out_word | output | 512 | Packed word, first byte in the top bits |
| out_last | output | 1 | Held word is the final word of its message |

## Verification
A byte accepted at a clock edge is in the held word right after that edge, so a word closed by a byte becomes valid in the same edge that accepts the byte. A read sampled at an edge clears the word after that edge. The bench drives inputs and samples outputs on the falling edge, and looks at `in_ready` a short delay after it drives the tag. It compares each valid word against a model that computes the packing from the byte offsets alone. It also checks that a held word stays unchanged across several cycles of withheld reads.

// File: rtl/alp_pkg.sv
// Shared types for the AAD/payload lane packer.
// Assumes: nothing beyond the standard.
package alp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_AAD  = 2'd1,
        PH_PAY  = 2'd2
    } phase_t;
endpackage

// File: rtl/alp_seq.sv
// Message sequencer: captures counts on start, tracks which stream is being
// collected, and flags the end of the AAD and the end of the message.
// Assumes: the byte buffer reports when it can take a byte (buf_free).
module alp_seq
    import alp_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] aad_len,
    input  logic [LEN_W-1:0] pay_len,
    input  logic             in_valid,
    input  logic             in_is_aad,
    input  logic             buf_free,
    output logic             in_ready,
    output logic             wr_en,
    output logic             aad_end,
    output logic             msg_end
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    phase_t           phase_q;
    logic [LEN_W-1:0] aad_left_q;
    logic [LEN_W-1:0] pay_left_q;

    // Accept only the tag of the stream now being collected.
    always_comb begin
        in_ready = buf_free &&
                   (((phase_q == PH_AAD) && in_is_aad) ||
                    ((phase_q == PH_PAY) && !in_is_aad));
        wr_en    = in_valid && in_ready;
        aad_end  = wr_en && (phase_q == PH_AAD) && (aad_left_q == ONE);
        msg_end  = (wr_en && (phase_q == PH_PAY) && (pay_left_q == ONE)) ||
                   (aad_end && (pay_left_q == '0));
    end

    // Count state: capture on start when idle, count down on each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            aad_left_q <= '0;
            pay_left_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        aad_left_q <= aad_len;
                        pay_left_q <= pay_len;
                        if (aad_len != '0)      phase_q <= PH_AAD;
                        else if (pay_len != '0) phase_q <= PH_PAY;
                    end
                end
                PH_AAD: begin
                    if (wr_en) begin
                        aad_left_q <= aad_left_q - ONE;
                        if (aad_left_q == ONE)
                            phase_q <= (pay_left_q != '0) ? PH_PAY : PH_IDLE;
                    end
                end
                PH_PAY: begin
                    if (wr_en) begin
                        pay_left_q <= pay_left_q - ONE;
                        if (pay_left_q == ONE) phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_IDLE_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> !wr_en); // R9
    AST_COUNTS_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> (pay_left_q <= $past(pay_left_q))); // R8
    AST_AAD_TAG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (phase_q == PH_AAD)) |-> in_is_aad); // R9
endmodule

// File: rtl/alp_word_buf.sv
// Word assembly buffer: writes bytes from the top of the word down, rounds
// the write position up to a lane boundary after the last AAD byte, and
// holds a completed word until it is read. Cleared to zero after each read.
// Assumes: wr_en is never raised while buf_free is low.
module alp_word_buf #(
    parameter int WORD_BYTES = 64,
    parameter int LANE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_byte,
    input  logic                    aad_end,
    input  logic                    msg_end,
    input  logic                    out_rd,
    output logic                    buf_free,
    output logic                    out_valid,
    output logic                    out_last,
    output logic [WORD_BYTES*8-1:0] out_word
);
    localparam int POS_W   = $clog2(WORD_BYTES);
    localparam int NX_W    = POS_W + 1;
    localparam int LANE_SH = $clog2(LANE_BYTES);
    localparam logic [NX_W-1:0] FULL_AT  = NX_W'(WORD_BYTES);
    localparam logic [NX_W-1:0] LANE_M1  = NX_W'(LANE_BYTES - 1);

    logic [POS_W-1:0] pos_q;
    logic [NX_W-1:0]  nx_pos;
    logic             close;
    logic             clear;
    logic             valid_q;
    logic             last_q;
    logic [7:0]       bytes_q [WORD_BYTES];

    // Next write position, rounded up to a lane after the final AAD byte.
    always_comb begin
        nx_pos = {1'b0, pos_q} + NX_W'(1);
        if (aad_end)
            nx_pos = ((nx_pos + LANE_M1) >> LANE_SH) << LANE_SH;
        close = wr_en && ((nx_pos == FULL_AT) || msg_end);
        clear = valid_q && out_rd;
    end

    assign buf_free  = !valid_q;
    assign out_valid = valid_q;
    assign out_last  = last_q;

    // Position and hold flags: close a word when full or final, free on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (clear) begin
            pos_q   <= '0;
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (wr_en) begin
            pos_q   <= close ? '0 : nx_pos[POS_W-1:0];
            valid_q <= close;
            last_q  <= close && msg_end;
        end
    end

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        // Byte slot b: zero on reset or read, loaded when the position hits it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                bytes_q[b] <= 8'h00;
            else if (wr_en && (pos_q == POS_W'(b)))
                bytes_q[b] <= wr_byte;
        end
        assign out_word[(WORD_BYTES-1-b)*8 +: 8] = bytes_q[b];
    end

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !valid_q); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !out_rd) |=> (valid_q && $stable(out_word) && $stable(last_q))); // R7
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_q |-> valid_q); // R6
    AST_LANE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (aad_end && !close) |=> (pos_q[LANE_SH-1:0] == '0)); // R2
endmodule

// File: rtl/aad_lane_packer.sv
// Top of the AAD/payload lane packer: joins the sequencer and the word buffer.
// Assumes: bytes arrive AAD first, then payload, as many as the counts say.
module aad_lane_packer #(
    parameter int LEN_W      = 16,
    parameter int WORD_BYTES = 64,
    parameter int LANE_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LEN_W-1:0]        aad_len,
    input  logic [LEN_W-1:0]        pay_len,
    input  logic                    in_valid,
    input  logic                    in_is_aad,
    input  logic [7:0]              in_byte,
    output logic                    in_ready,
    output logic                    out_valid,
    input  logic                    out_rd,
    output logic [WORD_BYTES*8-1:0] out_word,
    output logic                    out_last
);
    logic buf_free;
    logic wr_en;
    logic aad_end;
    logic msg_end;

    alp_seq #(.LEN_W(LEN_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .aad_len   (aad_len),
        .pay_len   (pay_len),
        .in_valid  (in_valid),
        .in_is_aad (in_is_aad),
        .buf_free  (buf_free),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .aad_end   (aad_end),
        .msg_end   (msg_end)
    );

    alp_word_buf #(.WORD_BYTES(WORD_BYTES), .LANE_BYTES(LANE_BYTES)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_byte   (in_byte),
        .aad_end   (aad_end),
        .msg_end   (msg_end),
        .out_rd    (out_rd),
        .buf_free  (buf_free),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_word  (out_word)
    );

    AST_READY_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7
endmodule

// File: tb/aad_lane_packer_tb_top.sv
module aad_lane_packer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [15:0]  aad_len = '0;
    logic [15:0]  pay_len = '0;
    logic         in_valid = 1'b0;
    logic         in_is_aad = 1'b0;
    logic [7:0]   in_byte = '0;
    logic         in_ready;
    logic         out_valid;
    logic         out_rd = 1'b0;
    logic [511:0] out_word;
    logic         out_last;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    aad_lane_packer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .aad_len(aad_len),
        .pay_len(pay_len), .in_valid(in_valid), .in_is_aad(in_is_aad),
        .in_byte(in_byte), .in_ready(in_ready), .out_valid(out_valid),
        .out_rd(out_rd), .out_word(out_word), .out_last(out_last)
    );

    // aad, pay, read stall cycles, disturb (restart + count change), wrong-tag probe
    localparam int NVEC = 9;
    localparam int VEC [NVEC][5] = '{
        '{78, 110, 0, 0, 0},   // R1 R2 R3 example layout
        '{0,   20, 0, 0, 0},   // R4
        '{16,   0, 0, 0, 0},   // R5
        '{21,   0, 2, 0, 0},   // R5 padded tail
        '{64,   5, 0, 0, 0},   // R3 next word
        '{3,    3, 3, 0, 1},   // R7 R9
        '{48,  16, 0, 0, 0},   // R3 fills lane 3
        '{100, 200, 1, 1, 0},  // R8
        '{0,    0, 0, 0, 0}    // R10
    };

    function automatic logic [7:0] aadb(int i);
        return 8'((i * 13 + 7) & 255);
    endfunction
    function automatic logic [7:0] payb(int i);
        return 8'((i * 29 + 101) & 255);
    endfunction

    // Model: AAD at offsets 0..A-1, payload from the lane boundary after it.
    function automatic logic [511:0] exp_word(int a, int p, int w);
        logic [511:0] r = '0;
        int off = ((a + 15) / 16) * 16;
        for (int b = 0; b < 64; b++) begin
            int g = w * 64 + b;
            logic [7:0] v = 8'h00;
            if (g < a) v = aadb(g);
            else if (g >= off && g < off + p) v = payb(g - off);
            r[511 - 8*b -: 8] = v;
        end
        return r;
    endfunction

    task automatic check(string req, logic [511:0] act, logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_msg(int a, int p, int stall, int disturb, int probe);
        int span = (p == 0) ? a : ((a + 15) / 16) * 16 + p;
        int nw = (span + 63) / 64;
        int g = 0;
        int words = 0;
        int hold = 0;
        int guard = 0;
        bit pulsed = 0;
        bit probed = 0;
        bit acc;
        bit prb;
        @(negedge clk);
        aad_len = 16'(a); pay_len = 16'(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb != 0) begin aad_len = 16'd7; pay_len = 16'd9; end
        while ((words < nw || g < a + p) && guard < 4000) begin
            guard++;
            out_rd = 1'b0; in_valid = 1'b0; start = 1'b0; prb = 1'b0;
            if (disturb != 0 && g == 2 && !pulsed) begin
                start = 1'b1; pulsed = 1'b1;
            end
            if (out_valid) begin
                if (hold < stall) begin
                    hold++;
                    if (g < a + p) begin
                        in_valid = 1'b1; in_is_aad = (g < a);
                        in_byte = (g < a) ? aadb(g) : payb(g - a);
                    end
                    if (hold == stall) begin
                        #1;
                        check("R7 held word", out_word, exp_word(a, p, words));
                        check("R7 in_ready while held", 512'(in_ready), 512'(0));
                    end
                end else begin
                    check(a == 0 ? "R4 word" : (p == 0 ? "R5 word" : "R1 R2 R3 R6 word"),
                          out_word, exp_word(a, p, words));
                    check("R6 last flag", 512'(out_last), 512'(words == nw - 1));
                    out_rd = 1'b1; hold = 0; words++;
                end
            end else if (g < a + p) begin
                in_valid = 1'b1;
                if (probe != 0 && !probed && g < a) begin
                    in_is_aad = 1'b0; in_byte = 8'hEE; probed = 1'b1; prb = 1'b1;
                end else begin
                    in_is_aad = (g < a);
                    in_byte = (g < a) ? aadb(g) : payb(g - a);
                end
            end
            #1;
            acc = in_valid && in_ready;
            if (prb) check("R9 wrong tag refused", 512'(in_ready), 512'(0));
            @(posedge clk);
            if (acc && !prb) g++;
            @(negedge clk);
        end
        out_rd = 1'b0; in_valid = 1'b0; start = 1'b0;
        check(nw == 0 ? "R10 word count" : "R7 word count", 512'(words), 512'(nw));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (out_valid) begin
                n_cmp++; n_bad++;
                $display("FAIL %s actual=extra word expected=none", nw == 0 ? "R10" : "R7");
            end
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 out_valid reset", 512'(out_valid), 512'(0));
        check("R11 out_last reset", 512'(out_last), 512'(0));
        check("R11 out_word reset", out_word, '0);
        in_valid = 1'b1; in_is_aad = 1'b1;
        #1;
        check("R11 in_ready reset", 512'(in_ready), 512'(0));
        in_valid = 1'b0;
        rst_n = 1'b1;
        for (int v = 0; v < NVEC; v++)
            run_msg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
        // R10: idle after an empty message refuses both tags
        @(negedge clk);
        in_valid = 1'b1; in_is_aad = 1'b1;
        #1;
        check("R10 idle refuses AAD", 512'(in_ready), 512'(0));
        in_is_aad = 1'b0;
        #1;
        check("R10 idle refuses payload", 512'(in_ready), 512'(0));
        in_valid = 1'b0;
        // R11: reset mid-message clears a held word
        run_msg(5, 1, 0, 0, 0);
        @(negedge clk);
        aad_len = 16'd64; pay_len = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 64; i++) begin
            in_valid = 1'b1; in_is_aad = 1'b1; in_byte = aadb(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check("R7 full word pending", 512'(out_valid), 512'(1));
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset clears word", {out_word[511:2], out_valid, out_last}, '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule